// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit down-counter with a small register interface. It runs in the system clock domain and advances on a single-cycle enable (`ref_tick`) that marks each period of a 32.768 kHz reference. An internal chain of four dividers turns that enable into four tick rates. A control register picks one of them and starts or stops the count.

Software writes a start value into the count register. That value also becomes the reload value. The counter steps down once per selected tick. When it completes a period, it reloads the start value, sets a sticky flag and can drive an active-low interrupt. The interrupt is either a short pulse for each period or a level that follows the flag. A read of the count register returns the live count.

The interface has two register addresses. Address 0 is control: bits [1:0] rate, bit 2 run, bit 3 interrupt enable, bit 4 pulse mode, bit 7 flag, and bits [6:5] read as zero. Address 1 is the count.

Top module: `tick_countdown_timer`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00 (stopped, flag clear, interrupt disabled), the count reads 0x00 and `irq_n` is high.
- R2: A write to address 1 loads the counter and the reload value at that clock edge, and later reads of address 1 return the live count as it falls.
- R3: Control bits [1:0] select the tick. 0 gives one tick per PRE_DIV0 reference ticks. 1 gives one per PRE_DIV0·PRE_DIV1. 2 gives one per PRE_DIV0·PRE_DIV1·PRE_DIV2. 3 gives one per the product of all four dividers. The defaults give 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz.
- R4: While control bit 2 (run) is 0, the count does not change except through a write to address 1.
- R5: On a selected tick with run set and a count of 1 or 0, a period completes. The counter takes the reload value and the flag (control bit 7) is set, so the period is N ticks for a start value N ≥ 1 and one tick for 0.
- R6: The flag stays set until software writes address 0 with bit 7 at 0. Writing bit 7 as 1 leaves the flag unchanged.
- R7: When a flag-clearing write and a period completion happen in the same cycle, the flag ends up set.
- R8: With interrupt enable (bit 3) set and pulse mode (bit 4) clear, `irq_n` is low exactly in the cycles in which the flag reads as set.
- R9: With interrupt enable set and pulse mode set, `irq_n` goes low in the cycle after a completion and goes high again after the next `ref_tick`.
- R10: With interrupt enable clear, `irq_n` stays high.
- R11: A write to address 1 restarts all prescaler stages. If the write falls in a cycle with a selected tick, that tick neither decrements the count nor completes a period.
- R12: `rd_data` is registered. It takes the addressed register's value from before the edge at which `rd_en` is sampled, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 count |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read address: 0 control, 1 count |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of events can land on the same clock edge. A software flag clear can meet a period completion, and a count-register write can meet a selected tick. The bench uses its reference model to predict the cycle in which the next completion or tick will occur. It issues the write in exactly that cycle, then reads back the flag or the count. A set flag after the collision confirms that completion wins. A count equal to the written value confirms that the write wins. Random traffic adds further unplanned collisions, and every read and every `irq_n` sample is compared against the model.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int REG_W   = 8;
  localparam int STAGES  = 4;
  localparam int RATE_W  = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SEC  = 2'd2,
    RATE_MIN  = 2'd3
  } rate_e;

  typedef struct packed {
    logic        pulse_mode;
    logic        irq_en;
    logic        run;
    rate_e       rate;
  } ctrl_t;

  localparam int BIT_RUN   = 2;
  localparam int BIT_IE    = 3;
  localparam int BIT_PULSE = 4;
  localparam int BIT_FLAG  = 7;

endpackage

// File: rtl/cdt_divstage.sv
module cdt_divstage #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic adv,
  output logic wrap
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign wrap = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STAGE_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> !wrap || (DIV == 1)); // R11
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler import cdt_pkg::*; #(
  parameter int PRE_DIV0 = 8,
  parameter int PRE_DIV1 = 64,
  parameter int PRE_DIV2 = 64,
  parameter int PRE_DIV3 = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              ref_tick,
  output logic [STAGES-1:0] ticks
);
  localparam int DIVS [STAGES] = '{PRE_DIV0, PRE_DIV1, PRE_DIV2, PRE_DIV3};

  logic [STAGES:0] chain;
  assign chain[0] = ref_tick;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cdt_divstage #(.DIV(DIVS[g])) i_stage (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .adv     (chain[g]),
      .wrap    (chain[g+1])
    );
  end

  assign ticks = chain[STAGES:1];

  AST_TICK_NESTED: assert property (@(posedge clk) disable iff (rst)
    ticks[3] |-> (ticks[2] && ticks[1] && ticks[0] && ref_tick)); // R3
endmodule

// File: rtl/cdt_core.sv
module cdt_core import cdt_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_sel,
  input  logic             run,
  input  logic             cnt_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [REG_W-1:0] cnt,
  output logic             flag,
  output logic             flag_nxt,
  output logic             done
);
  logic [REG_W-1:0] cnt_q, reload_q;
  logic             flag_q;
  logic             step;
  logic             at_end;

  assign at_end   = (cnt_q <= REG_W'(1));
  assign step     = !cnt_wr && run && tick_sel;
  assign done     = step && at_end;
  assign flag_nxt = done || (flag_q && !flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      if (cnt_wr) begin
        cnt_q    <= wdata;
        reload_q <= wdata;
      end else if (step) begin
        if (at_end) cnt_q <= reload_q;
        else        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(wdata))); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !run) |=> $stable(cnt)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (done && flag_clr) |=> flag); // R7
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic done,
  input  logic flag_nxt,
  input  logic irq_en,
  input  logic pulse_mode,
  output logic irq_n
);
  logic pulse_q, pulse_nxt, irq_n_q;

  always_comb begin
    if (done)          pulse_nxt = 1'b1;
    else if (ref_tick) pulse_nxt = 1'b0;
    else               pulse_nxt = pulse_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      pulse_q <= pulse_nxt;
      irq_n_q <= !(irq_en && (pulse_mode ? pulse_nxt : flag_nxt));
    end
  end

  assign irq_n = irq_n_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> irq_n); // R10
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && ref_tick && !done) |=> irq_n); // R9
  AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && irq_en && done) |=> !irq_n); // R9
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer import cdt_pkg::*; #(
  parameter int PRE_DIV0 = 8,
  parameter int PRE_DIV1 = 64,
  parameter int PRE_DIV2 = 64,
  parameter int PRE_DIV3 = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  ctrl_t             ctrl_q;
  logic [STAGES-1:0] ticks;
  logic              cnt_wr, ctrl_wr, flag_clr;
  logic [REG_W-1:0]  cnt;
  logic              flag, flag_nxt, done;
  logic [REG_W-1:0]  ctrl_image;
  logic [REG_W-1:0]  rd_q;
  logic              unused_rsv;

  assign cnt_wr     = wr_en && wr_addr;
  assign ctrl_wr    = wr_en && !wr_addr;
  assign flag_clr   = ctrl_wr && !wr_data[BIT_FLAG];
  assign unused_rsv = ^wr_data[6:5];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.rate       <= rate_e'(wr_data[RATE_W-1:0]);
      ctrl_q.run        <= wr_data[BIT_RUN];
      ctrl_q.irq_en     <= wr_data[BIT_IE];
      ctrl_q.pulse_mode <= wr_data[BIT_PULSE];
    end
  end

  cdt_prescaler #(
    .PRE_DIV0 (PRE_DIV0),
    .PRE_DIV1 (PRE_DIV1),
    .PRE_DIV2 (PRE_DIV2),
    .PRE_DIV3 (PRE_DIV3)
  ) i_prescaler (
    .clk      (clk),
    .rst      (rst),
    .restart  (cnt_wr),
    .ref_tick (ref_tick),
    .ticks    (ticks)
  );

  cdt_core i_core (
    .clk      (clk),
    .rst      (rst),
    .tick_sel (ticks[ctrl_q.rate]),
    .run      (ctrl_q.run),
    .cnt_wr   (cnt_wr),
    .wdata    (wr_data),
    .flag_clr (flag_clr),
    .cnt      (cnt),
    .flag     (flag),
    .flag_nxt (flag_nxt),
    .done     (done)
  );

  cdt_irq i_irq (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .done       (done),
    .flag_nxt   (flag_nxt),
    .irq_en     (ctrl_q.irq_en),
    .pulse_mode (ctrl_q.pulse_mode),
    .irq_n      (irq_n)
  );

  assign ctrl_image = {flag, 2'b00, ctrl_q.pulse_mode, ctrl_q.irq_en,
                       ctrl_q.run, ctrl_q.rate};

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_addr ? cnt : ctrl_image;
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R12
  AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.irq_en && !ctrl_q.pulse_mode && !ctrl_wr) |=> (irq_n == !flag)); // R8
endmodule

// File: tb/test_tick_countdown_timer.sv
module test_tick_countdown_timer;
  localparam int P0 = 2, P1 = 3, P2 = 2, P3 = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tick_countdown_timer #(.PRE_DIV0(P0), .PRE_DIV1(P1), .PRE_DIV2(P2), .PRE_DIV3(P3))
    i_tick_countdown_timer (
      .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_n(irq_n));

  // reference model state
  int         md [4] = '{P0, P1, P2, P3};
  int         mc [4];
  logic [7:0] m_cnt, m_rel, m_rd;
  logic [1:0] m_rate;
  logic       m_run, m_ie, m_pm, m_flag, m_pulse, m_irqn;

  function automatic logic [7:0] ctrl_img();
    return {m_flag, 2'b00, m_pm, m_ie, m_run, m_rate};
  endfunction

  function automatic logic tick_now(input logic r);
    logic ch = r;
    logic [3:0] tk;
    for (int i = 0; i < 4; i++) begin
      tk[i] = ch && (mc[i] == md[i] - 1);
      ch = tk[i];
    end
    return tk[m_rate];
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) mc[i] = 0;
    m_cnt = 0; m_rel = 0; m_rd = 0; m_rate = 0; m_run = 0; m_ie = 0; m_pm = 0;
    m_flag = 0; m_pulse = 0; m_irqn = 1;
  endtask

  task automatic cyc(input logic r, input logic we, input logic wa, input logic [7:0] wd,
                     input logic re, input logic ra, input string tag);
    logic ch, tsel, cwr, kwr, ev, dec, fl_n, pu_n;
    logic [3:0] tk;
    string itag;
    @(negedge clk);
    ref_tick = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    ch = r;
    for (int i = 0; i < 4; i++) begin
      tk[i] = ch && (mc[i] == md[i] - 1);
      ch = tk[i];
    end
    tsel = tk[m_rate];
    cwr = we && wa;
    kwr = we && !wa;
    ev  = !cwr && m_run && tsel && (m_cnt <= 1);
    dec = !cwr && m_run && tsel && (m_cnt > 1);
    fl_n = ev || (m_flag && !(kwr && !wd[7]));
    pu_n = ev ? 1'b1 : (r ? 1'b0 : m_pulse);
    itag = !m_ie ? "R10" : (m_pm ? "R9" : "R8");
    @(posedge clk);
    m_irqn = !(m_ie && (m_pm ? pu_n : fl_n));
    if (re) m_rd = ra ? m_cnt : ctrl_img();
    if (cwr) begin
      for (int i = 0; i < 4; i++) mc[i] = 0;
    end else begin
      ch = r;
      for (int i = 0; i < 4; i++) begin
        if (ch) mc[i] = (mc[i] == md[i] - 1) ? 0 : mc[i] + 1;
        ch = tk[i];
      end
    end
    if (cwr) begin m_cnt = wd; m_rel = wd; end
    else if (dec) m_cnt = m_cnt - 1;
    else if (ev) m_cnt = m_rel;
    if (kwr) begin
      m_rate = wd[1:0]; m_run = wd[2]; m_ie = wd[3]; m_pm = wd[4];
    end
    m_flag = fl_n;
    m_pulse = pu_n;
    #1;
    chk(itag, "irq_n", {7'd0, irq_n}, {7'd0, m_irqn});
    if (re) chk(tag, "rd_data", rd_data, m_rd);
  endtask

  task automatic idle(input int n, input logic r, input logic ra, input string tag);
    for (int i = 0; i < n; i++) cyc(r, 0, 0, 8'h00, 1, ra, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1; chk("R1", "irq_n in reset", {7'd0, irq_n}, 8'h01);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    cyc(0, 0, 0, 0, 1, 0, "R1");
    chk("R1", "ctrl", rd_data, 8'h00);
    cyc(0, 0, 0, 0, 1, 1, "R1");
    chk("R1", "count", rd_data, 8'h00);

    // R2 load and live readback
    cyc(0, 1, 1, 8'd5, 0, 0, "R2");
    cyc(0, 0, 0, 0, 1, 1, "R2");
    chk("R2", "loaded count", rd_data, 8'd5);
    cyc(1, 1, 0, 8'h04, 0, 0, "R2");
    idle(8, 1, 1, "R2");

    // R3 each rate
    for (int rt = 0; rt < 4; rt++) begin
      cyc(1, 1, 0, 8'h04 | rt[1:0], 0, 0, "R3");
      cyc(1, 1, 1, 8'd3, 0, 0, "R3");
      idle(60, 1, 1, "R3");
    end

    // R4 stopped counter
    cyc(1, 1, 1, 8'd9, 0, 0, "R4");
    cyc(1, 1, 0, 8'h00, 0, 0, "R4");
    idle(20, 1, 1, "R4");
    chk("R4", "frozen count", rd_data, 8'd9);

    // R5/R6 completion and sticky flag, start value 2 then 0
    cyc(1, 1, 1, 8'd2, 0, 0, "R5");
    cyc(1, 1, 0, 8'h84, 0, 0, "R5");
    idle(12, 1, 0, "R5");
    chk("R5", "flag set", rd_data & 8'h80, 8'h80);
    cyc(1, 1, 1, 8'd0, 0, 0, "R5");
    idle(10, 1, 1, "R5");
    cyc(1, 1, 0, 8'h80, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, "R6");
    chk("R6", "flag kept", rd_data & 8'h80, 8'h80);
    cyc(0, 1, 0, 8'h00, 0, 0, "R6");
    idle(5, 1, 0, "R6");
    chk("R6", "flag cleared", rd_data & 8'h80, 8'h00);

    // R8 level interrupt
    cyc(1, 1, 1, 8'd3, 0, 0, "R8");
    cyc(1, 1, 0, 8'h0C, 0, 0, "R8");
    idle(20, 1, 0, "R8");
    cyc(1, 1, 0, 8'h0C, 1, 0, "R8");
    idle(4, 0, 0, "R8");

    // R9 pulse interrupt with sparse reference ticks
    cyc(0, 1, 0, 8'h1C, 0, 0, "R9");
    for (int i = 0; i < 80; i++) cyc(($urandom % 3) == 0, 0, 0, 0, 1, 1, "R9");

    // R7 clear collides with completion
    cyc(1, 1, 1, 8'd1, 0, 0, "R7");
    cyc(1, 1, 0, 8'h04, 0, 0, "R7");
    for (int i = 0; i < 50; i++) begin
      if (m_run && tick_now(1) && m_cnt <= 1) begin
        cyc(1, 1, 0, 8'h04, 0, 0, "R7");
        break;
      end
      cyc(1, 1, 0, 8'h04, 0, 0, "R7");
    end
    cyc(0, 0, 0, 0, 1, 0, "R7");
    chk("R7", "flag after collision", rd_data & 8'h80, 8'h80);

    // R11 count write on a tick cycle
    cyc(1, 1, 1, 8'd7, 0, 0, "R11");
    for (int i = 0; i < 50; i++) begin
      if (tick_now(1)) begin
        cyc(1, 1, 1, 8'd6, 0, 0, "R11");
        break;
      end
      cyc(1, 0, 0, 0, 0, 0, "R11");
    end
    cyc(0, 0, 0, 0, 1, 1, "R11");
    chk("R11", "write beats tick", rd_data, 8'd6);
    idle(10, 1, 1, "R11");

    // R12 read in a decrement cycle returns pre-edge count
    cyc(1, 1, 1, 8'd8, 0, 0, "R12");
    for (int i = 0; i < 10; i++) begin
      if (tick_now(1)) begin
        cyc(1, 0, 0, 0, 1, 1, "R12");
        chk("R12", "pre-edge count", rd_data, 8'd8);
        break;
      end
      cyc(1, 0, 0, 0, 0, 0, "R12");
    end

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom % 100;
      logic r = ($urandom % 2) == 0;
      if (sel < 3)      cyc(r, 1, 0, 8'($urandom) & 8'h9F, 1, 0, "R6");
      else if (sel < 6) cyc(r, 1, 1, 8'($urandom % 6), 1, 1, "R11");
      else              cyc(r, 0, 0, 0, 1, ($urandom % 2) == 0, "R2");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule